// File: doc/BRIEF.md
# Wide-access UART FIFO port

This block connects a simple memory-mapped host bus to one UART channel's transmit and receive queues. Both queues are 256 entries deep. Each receive entry holds a data byte and the four line-status error flags that came with it. The host reaches the queues through a small per-channel address window. A byte-wide holding-register location gives the classic one-byte-at-a-time access. A FIFO burst window moves one to four bytes per access. A data-plus-status window returns received bytes fused with their error flags, so software never has to read line status separately.

The host side has an address, a two-bit size code and read and write strobes. The size code gives the byte count minus one: 0 is 8-bit, 1 is 16-bit, 2 is 24-bit and 3 is 32-bit. A read answers in the next cycle with the data, a valid flag and the count of entries it returned. The serial side pushes received bytes with their flags. It sees the oldest transmit byte at its output and removes it with a pop strobe.

The channel's window is picked by the address bits above bit 9, which must equal the channel number. Within the window:
- offset 0x000 is the holding register;
- offsets 0x100 to 0x1FF are the FIFO burst window;
- offsets 0x200 to 0x3FF are the data-plus-status window.

Top module: `uart_wide_fifo_port`

## Requirements
- R1: While reset is asserted and after it is released, host_rvalid, host_rdata and host_rcount are 0, tx_empty is 1, tx_ovf is 0 and rx_full is 0.
- R2: host_rvalid is 1 in exactly the cycle after a cycle with host_rd high, and 0 after a cycle without it. host_rdata and host_rcount are valid in that same cycle.
- R3: A FIFO-window read of size code s pops min(s+1, entries held) receive entries. The oldest entry is placed in bits 7:0 and the following entries go in the next byte lanes up. host_rcount gives the number popped, and lanes without data read as 0.
- R4: A FIFO-window write of size code s pushes byte lanes 0 through s of host_wdata in lane order. tx_data shows the oldest byte, and tx_pop removes it when tx_empty is 0.
- R5: Write bytes that find the transmit queue full are dropped, while earlier lanes of the same write are still accepted. A drop sets tx_ovf, which stays 1 until reset.
- R6: A data-plus-status read of size code 1 pops one entry and returns its data in bits 7:0 and its 4-bit flags in bits 11:8. Size code 3 pops up to two entries: the second entry's data goes in bits 23:16 and its flags in bits 27:24. host_rcount counts the entries popped.
- R7: A data-plus-status read of size code 0 or 2 returns 0 with host_rcount 0 and pops nothing. Writes to the data-plus-status window push nothing.
- R8: At the holding-register offset, an 8-bit read pops one entry and returns only its data byte, with bits 31:8 at 0. An 8-bit write pushes lane 0. Accesses there with any other size code have no effect and read as 0.
- R9: Every address inside a window selects that window, whatever the offset within it. Successive burst addresses therefore keep draining or filling the same queue.
- R10: Accesses outside the decoded windows return 0 with host_rcount 0 and change neither queue. This covers the other channel's addresses and offsets 0x001 to 0x0FF.
- R11: The receive queue holds 256 entries. rx_full is 1 when it is full, and a push while full is dropped. 64 successive 32-bit FIFO-window reads drain a full queue.
- R12: In a cycle with both host_rd and host_wr high, only the read is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 11 | Host byte address |
| host_size | input | 2 | Access size code, bytes minus one |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response valid |
| host_rcount | output | 3 | Entries returned by the read |
| rx_push | input | 1 | Received byte strobe from the serial side |
| rx_byte | input | 8 | Received data byte |
| rx_stat | input | 4 | Error flags of the received byte |
| rx_full | output | 1 | Receive queue full |
| tx_pop | input | 1 | Serial side takes the oldest transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit queue empty |
| tx_ovf | output | 1 | Sticky transmit overflow flag |

## Verification
The bench probes several corner cases:
- A partial read of a nearly empty queue. A design that fills the unused lanes with stale memory, or that pops past the count, returns wrong upper lanes or wrong later bytes.
- A data-plus-status read with an unsupported size, and a wide holding-register access. A design that still pops on these loses a byte, which the next read exposes.
- A write that straddles the full point of the transmit queue. A design that drops the whole write, or that wraps over the oldest bytes, breaks the ordered 0 to 255 sequence seen at tx_data.
- A push into a full receive queue, and a cycle with both strobes high. A design that mishandles these overwrites the head or pushes a stray transmit byte.

// File: rtl/uwp_pkg.sv
package uwp_pkg;
    localparam int BYTE_W = 8;
    localparam int STAT_W = 4;
    localparam int LANES  = 4;
    localparam int OFS_W  = 10;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_HOLD,
        RGN_FIFO,
        RGN_STAT
    } region_e;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [BYTE_W-1:0] data;
    } rx_ent_t;
endpackage

// File: rtl/uwp_decode.sv
module uwp_decode
    import uwp_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int CHAN_ID = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    localparam int CHAN_W = ADDR_W - OFS_W;

    logic [CHAN_W-1:0] chan;
    logic [OFS_W-1:0]  ofs;

    always_comb begin
        chan = addr[ADDR_W-1:OFS_W];
        ofs  = addr[OFS_W-1:0];
        if (chan != CHAN_W'(CHAN_ID)) begin
            region = RGN_NONE;
        end else if (ofs[OFS_W-1]) begin
            region = RGN_STAT;
        end else if (ofs[OFS_W-2]) begin
            region = RGN_FIFO;
        end else if (ofs == '0) begin
            region = RGN_HOLD;
        end else begin
            region = RGN_NONE;
        end
    end
endmodule

// File: rtl/uwp_ring.sv
module uwp_ring #(
    parameter int W     = 8,
    parameter int DEPTH = 256,
    parameter int NIN   = 1,
    parameter int NOUT  = 1,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(NIN + 1),
    localparam int OW = $clog2(NOUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] push_req,
    input  logic [W-1:0]  push_data [NIN],
    input  logic [OW-1:0] pop_req,
    output logic [IW-1:0] push_acc,
    output logic [OW-1:0] pop_acc,
    output logic [W-1:0]  head [NOUT],
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] rptr;
        logic [AW-1:0] wptr;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t         st_d, st_q;
    logic [CW-1:0] free_d;
    logic [W-1:0]  mem [DEPTH];

    always_comb begin
        free_d = CW'(DEPTH) - st_q.cnt;
        if (CW'(push_req) > free_d) begin
            push_acc = IW'(free_d);
        end else begin
            push_acc = push_req;
        end
        if (CW'(pop_req) > st_q.cnt) begin
            pop_acc = OW'(st_q.cnt);
        end else begin
            pop_acc = pop_req;
        end
        st_d      = st_q;
        st_d.wptr = st_q.wptr + AW'(push_acc);
        st_d.rptr = st_q.rptr + AW'(pop_acc);
        st_d.cnt  = st_q.cnt + CW'(push_acc) - CW'(pop_acc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NIN; i++) begin
            if (i < int'(push_acc)) begin
                mem[st_q.wptr + AW'(i)] <= push_data[i];
            end
        end
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_head
        assign head[g] = mem[st_q.rptr + AW'(g)];
    end

    assign count = st_q.cnt;

    // R11: occupancy never passes the depth
    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R3: a pop never takes more entries than are held
    a_r3_pop_within_count: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_acc) <= count);
    // R10: with no traffic the occupancy holds
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (push_acc == '0 && pop_acc == '0) |=> $stable(count));
endmodule

// File: rtl/uart_wide_fifo_port.sv
module uart_wide_fifo_port
    import uwp_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int CHAN_ID = 0,
    parameter int DEPTH   = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic [1:0]                host_size,
    input  logic                      host_rd,
    input  logic                      host_wr,
    input  logic [LANES*BYTE_W-1:0]   host_wdata,
    output logic [LANES*BYTE_W-1:0]   host_rdata,
    output logic                      host_rvalid,
    output logic [2:0]                host_rcount,
    input  logic                      rx_push,
    input  logic [BYTE_W-1:0]         rx_byte,
    input  logic [STAT_W-1:0]         rx_stat,
    output logic                      rx_full,
    input  logic                      tx_pop,
    output logic [BYTE_W-1:0]         tx_data,
    output logic                      tx_empty,
    output logic                      tx_ovf
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int DW = LANES * BYTE_W;
    localparam int RW = BYTE_W + STAT_W;

    typedef struct packed {
        logic          rvalid;
        logic [DW-1:0] rdata;
        logic [2:0]    rcount;
        logic          ovf;
    } resp_t;

    resp_t   rs_d, rs_q;
    region_e region;

    logic [2:0]        nbytes;
    logic              do_rd, do_wr;
    logic [2:0]        rx_pop_req, rx_pop_acc;
    logic [2:0]        tx_push_req, tx_push_acc;
    logic [RW-1:0]     rx_head [LANES];
    logic [RW-1:0]     rx_in   [1];
    logic [BYTE_W-1:0] tx_in   [LANES];
    logic [BYTE_W-1:0] tx_head [1];
    logic              rx_push_acc, tx_pop_acc;
    logic [CW-1:0]     rx_cnt, tx_cnt;
    rx_ent_t           ent;

    uwp_decode #(.ADDR_W(ADDR_W), .CHAN_ID(CHAN_ID)) u_dec (
        .addr   (host_addr),
        .region (region)
    );

    assign rx_in[0] = {rx_stat, rx_byte};

    uwp_ring #(.W(RW), .DEPTH(DEPTH), .NIN(1), .NOUT(LANES)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (rx_push),
        .push_data (rx_in),
        .pop_req   (rx_pop_req),
        .push_acc  (rx_push_acc),
        .pop_acc   (rx_pop_acc),
        .head      (rx_head),
        .count     (rx_cnt)
    );

    uwp_ring #(.W(BYTE_W), .DEPTH(DEPTH), .NIN(LANES), .NOUT(1)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (tx_push_req),
        .push_data (tx_in),
        .pop_req   (tx_pop & ~tx_empty),
        .push_acc  (tx_push_acc),
        .pop_acc   (tx_pop_acc),
        .head      (tx_head),
        .count     (tx_cnt)
    );

    always_comb begin
        nbytes      = {1'b0, host_size} + 3'd1;
        do_rd       = host_rd;
        do_wr       = host_wr & ~host_rd;
        rx_pop_req  = '0;
        tx_push_req = '0;
        for (int i = 0; i < LANES; i++) begin
            tx_in[i] = host_wdata[i*BYTE_W +: BYTE_W];
        end
        unique case (region)
            RGN_FIFO: begin
                if (do_rd) rx_pop_req  = nbytes;
                if (do_wr) tx_push_req = nbytes;
            end
            RGN_STAT: begin
                if (do_rd && host_size[0]) rx_pop_req = host_size[1] ? 3'd2 : 3'd1;
            end
            RGN_HOLD: begin
                if (host_size == 2'd0) begin
                    if (do_rd) rx_pop_req  = 3'd1;
                    if (do_wr) tx_push_req = 3'd1;
                end
            end
            default: ;
        endcase

        rs_d        = rs_q;
        rs_d.rvalid = do_rd;
        rs_d.rcount = do_rd ? rx_pop_acc : 3'd0;
        rs_d.rdata  = '0;
        rs_d.ovf    = rs_q.ovf | (tx_push_acc != tx_push_req);
        for (int i = 0; i < LANES; i++) begin
            ent = rx_head[i];
            if (i < int'(rx_pop_acc)) begin
                if (region == RGN_STAT) begin
                    rs_d.rdata[2*i*BYTE_W +: BYTE_W]     = ent.data;
                    rs_d.rdata[(2*i+1)*BYTE_W +: BYTE_W] = BYTE_W'(ent.stat);
                end else begin
                    rs_d.rdata[i*BYTE_W +: BYTE_W] = ent.data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign host_rvalid = rs_q.rvalid;
    assign host_rdata  = rs_q.rdata;
    assign host_rcount = rs_q.rcount;
    assign tx_ovf      = rs_q.ovf;
    assign tx_data     = tx_head[0];
    assign tx_empty    = (tx_cnt == '0);
    assign rx_full     = (rx_cnt == CW'(DEPTH));

    // R2: a response follows every read strobe, and only a read strobe
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);
    // R3: a response with no entries carries all-zero lanes
    a_r3_empty_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && host_rcount == 3'd0) |-> host_rdata == '0);
    // R5: the overflow flag stays set
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> tx_ovf);
    // R8: the holding register returns no flags
    a_r8_hold_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && region == RGN_HOLD) |=> host_rdata[DW-1:BYTE_W] == '0);
    // R10: reads outside the windows return nothing
    a_r10_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && region == RGN_NONE) |=> (host_rcount == 3'd0 && host_rdata == '0));
    // R12: a read in the same cycle as a write pushes nothing
    a_r12_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_wr) |-> tx_push_acc == '0);
    // R11: a receive push is accepted unless the queue is full
    a_r11_rx_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_full) |-> rx_push_acc);
    // R4: the transmit side pops only when it holds data
    a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_acc |-> !tx_empty);
endmodule

// File: tb/sim_uart_wide_fifo_port.sv
module sim_uart_wide_fifo_port;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  op;
        logic [10:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [31:0] expv;
        logic [2:0]  cnt;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    // op: 0 rx push {stat,data}; 1 host read; 2 host write; 3 tx pop check
    localparam vec_t VEC [NV] = '{
        '{2'd0, 11'h000, 2'd0, 32'h011, 32'h0, 3'd0, 4'd3},
        '{2'd0, 11'h000, 2'd0, 32'h322, 32'h0, 3'd0, 4'd3},
        '{2'd0, 11'h000, 2'd0, 32'h033, 32'h0, 3'd0, 4'd3},
        '{2'd0, 11'h000, 2'd0, 32'h844, 32'h0, 3'd0, 4'd3},
        '{2'd0, 11'h000, 2'd0, 32'h155, 32'h0, 3'd0, 4'd3},
        '{2'd1, 11'h100, 2'd1, 32'h0, 32'h0000_2211, 3'd2, 4'd3},  // R3
        '{2'd1, 11'h1FC, 2'd3, 32'h0, 32'h0055_4433, 3'd3, 4'd9},  // R9
        '{2'd1, 11'h104, 2'd3, 32'h0, 32'h0000_0000, 3'd0, 4'd3},  // R3
        '{2'd0, 11'h000, 2'd0, 32'h2A1, 32'h0, 3'd0, 4'd6},
        '{2'd0, 11'h000, 2'd0, 32'h5A2, 32'h0, 3'd0, 4'd6},
        '{2'd0, 11'h000, 2'd0, 32'h0A3, 32'h0, 3'd0, 4'd6},
        '{2'd1, 11'h200, 2'd3, 32'h0, 32'h05A2_02A1, 3'd2, 4'd6},  // R6
        '{2'd1, 11'h200, 2'd0, 32'h0, 32'h0000_0000, 3'd0, 4'd7},  // R7
        '{2'd1, 11'h3FE, 2'd1, 32'h0, 32'h0000_00A3, 3'd1, 4'd6},  // R6
        '{2'd0, 11'h000, 2'd0, 32'hFB1, 32'h0, 3'd0, 4'd8},
        '{2'd1, 11'h000, 2'd1, 32'h0, 32'h0000_0000, 3'd0, 4'd8},  // R8
        '{2'd1, 11'h080, 2'd0, 32'h0, 32'h0000_0000, 3'd0, 4'd10}, // R10
        '{2'd1, 11'h500, 2'd3, 32'h0, 32'h0000_0000, 3'd0, 4'd10}, // R10
        '{2'd1, 11'h000, 2'd0, 32'h0, 32'h0000_00B1, 3'd1, 4'd8},  // R8
        '{2'd2, 11'h100, 2'd2, 32'hDDC3_C2C1, 32'h0, 3'd0, 4'd4},  // R4
        '{2'd2, 11'h000, 2'd0, 32'h0000_00E1, 32'h0, 3'd0, 4'd8},
        '{2'd2, 11'h000, 2'd1, 32'h0000_FFFF, 32'h0, 3'd0, 4'd8},
        '{2'd2, 11'h200, 2'd3, 32'h1234_5678, 32'h0, 3'd0, 4'd7},
        '{2'd2, 11'h040, 2'd3, 32'h8765_4321, 32'h0, 3'd0, 4'd10},
        '{2'd2, 11'h500, 2'd3, 32'hAABB_CCDD, 32'h0, 3'd0, 4'd10},
        '{2'd3, 11'h000, 2'd0, 32'h0, 32'h0000_00C1, 3'd0, 4'd4},
        '{2'd3, 11'h000, 2'd0, 32'h0, 32'h0000_00C2, 3'd0, 4'd4},
        '{2'd3, 11'h000, 2'd0, 32'h0, 32'h0000_00C3, 3'd0, 4'd4},
        '{2'd3, 11'h000, 2'd0, 32'h0, 32'h0000_00E1, 3'd0, 4'd8},
        '{2'd3, 11'h000, 2'd0, 32'h0, 32'h0000_0000, 3'd0, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic [2:0]  host_rcount;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [3:0]  rx_stat = '0;
    logic        rx_full;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_empty, tx_ovf;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_wide_fifo_port u0 (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_size(host_size),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_rcount(host_rcount),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_stat(rx_stat), .rx_full(rx_full),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty), .tx_ovf(tx_ovf)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic do_rxpush(input logic [11:0] v);
        @(negedge clk);
        rx_push = 1'b1; rx_byte = v[7:0]; rx_stat = v[11:8];
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic do_read(input logic [10:0] a, input logic [1:0] s);
        @(negedge clk);
        host_addr = a; host_size = s; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic do_write(input logic [10:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_size = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_txpop(input int req, input logic [7:0] expv);
        @(negedge clk);
        check(req, "tx_data", {24'd0, tx_data}, {24'd0, expv});
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, "rvalid in reset", {31'd0, host_rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "rvalid", {31'd0, host_rvalid}, 32'd0);
        check(1, "rdata", host_rdata, 32'd0);
        check(1, "rcount", {29'd0, host_rcount}, 32'd0);
        check(1, "tx_empty", {31'd0, tx_empty}, 32'd1);
        check(1, "tx_ovf", {31'd0, tx_ovf}, 32'd0);
        check(1, "rx_full", {31'd0, rx_full}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            case (VEC[k].op)
                2'd0: do_rxpush(VEC[k].wdata[11:0]);
                2'd1: begin
                    do_read(VEC[k].addr, VEC[k].size);
                    check(2, "rvalid after read", {31'd0, host_rvalid}, 32'd1);
                    check(int'(VEC[k].req), "rdata", host_rdata, VEC[k].expv);
                    check(int'(VEC[k].req), "rcount", {29'd0, host_rcount}, {29'd0, VEC[k].cnt});
                    @(negedge clk);
                    check(2, "rvalid idle", {31'd0, host_rvalid}, 32'd0);
                end
                2'd2: do_write(VEC[k].addr, VEC[k].size, VEC[k].wdata);
                default: begin
                    if (VEC[k].expv == 32'd0) begin
                        // R10 R7: ignored writes left nothing behind
                        check(int'(VEC[k].req), "tx_empty after pops", {31'd0, tx_empty}, 32'd1);
                    end else begin
                        do_txpop(int'(VEC[k].req), VEC[k].expv[7:0]);
                    end
                end
            endcase
        end

        // R5: fill to 254, then a write straddling the full point
        for (int i = 0; i < 63; i++) begin
            do_write(11'h100 + 11'(4*i), 2'd3,
                     {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
        end
        do_write(11'h1F0, 2'd1, 32'h0000_FDFC);
        check(5, "tx_ovf before full", {31'd0, tx_ovf}, 32'd0);
        do_write(11'h1F4, 2'd3, 32'h0201_FFFE);
        check(5, "tx_ovf after drop", {31'd0, tx_ovf}, 32'd1);
        for (int i = 0; i < 256; i++) begin
            do_txpop(5, 8'(i));
        end
        check(5, "tx_empty after drain", {31'd0, tx_empty}, 32'd1);
        check(5, "tx_ovf sticky", {31'd0, tx_ovf}, 32'd1);

        // R11: fill receive queue, overfill, drain with 32-bit reads
        for (int i = 0; i < 257; i++) begin
            do_rxpush({4'(i), 8'(i)});
        end
        check(11, "rx_full", {31'd0, rx_full}, 32'd1);
        for (int j = 0; j < 64; j++) begin
            do_read(11'h100 + 11'(4*j), 2'd3);
            check(11, "drain word", host_rdata,
                  {8'(4*j+3), 8'(4*j+2), 8'(4*j+1), 8'(4*j)});
            check(11, "drain count", {29'd0, host_rcount}, 32'd4);
        end
        check(11, "rx_full cleared", {31'd0, rx_full}, 32'd0);
        do_read(11'h100, 2'd3);
        check(11, "extra push dropped", {29'd0, host_rcount}, 32'd0);

        // R12: read and write strobes together
        do_rxpush(12'h077);
        @(negedge clk);
        host_addr = 11'h100; host_size = 2'd0; host_wdata = 32'h99;
        host_rd = 1'b1; host_wr = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        check(12, "rdata", host_rdata, 32'h77);
        check(12, "tx_empty", {31'd0, tx_empty}, 32'd1);

        finish_run();
    end
endmodule